// File: doc/BRIEF.md
# Burst Read Word Address Sequencer

This block produces the sequence of word addresses for a synchronous burst read from a memory array. A pulse on `start` loads a starting word address. From the next cycle the block presents one word address per beat on a valid/ready output stream. Each accepted beat moves the address on by one word, following the burst mode held in a small configuration register.

There are four burst modes. Continuous mode counts upward with no beat limit and rolls over from the top of the address space to zero. The three wrap modes (8, 16 and 32 words) count inside the aligned window of that size that holds the starting word. At the end of the window they return to its first word, and they stop after exactly N beats, on the word just before the starting word. A wrap burst therefore never leaves its 64-word aligned block.

The mode register is written by an upstream command decoder. That decoder has already picked the two mode-select address lines out of the configuration write, so this block sees a two-bit field and a write strobe. The mode is latched when a burst starts, so a configuration write during a burst has no effect on that burst. Deasserting `ce` ends any burst on the next clock edge.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `beat_valid` is 0 and the burst mode is continuous, so a burst started with no configuration write counts straight across 64-word boundaries.
- R2: On a clock edge with `cfg_wr` high, the mode register takes `cfg_mode`, with the encoding 00 = continuous, 01 = 8-word wrap, 10 = 16-word wrap, 11 = 32-word wrap.
- R3: A clock edge with `ce` and `start` both high loads `start_addr`. In the next cycle `beat_valid` is 1 and `beat_addr` equals `start_addr`. A start takes priority over a beat advance and restarts any burst that is running.
- R4: In continuous mode, each accepted beat (`beat_valid` and `beat_ready` both high at a clock edge) increments `beat_addr` by one, modulo 2^ADDR_W, with no limit on the number of beats.
- R5: In N-word wrap mode, each accepted beat sets the low log2(N) address bits to their value plus one, modulo N, and leaves the upper bits unchanged. After the Nth accepted beat, `beat_valid` drops to 0.
- R6: During a wrap-mode burst, bits ADDR_W-1..6 of `beat_addr` never change, so the burst stays inside one 64-word block.
- R7: In wrap mode, a start address aligned to N gives the plain ascending sequence from the start address to the start address plus N-1.
- R8: While `beat_valid` is 1 and `beat_ready` is 0, the next cycle keeps `beat_valid` at 1 and `beat_addr` unchanged (provided `ce` stays high and `start` stays low).
- R9: A clock edge with `ce` low makes `beat_valid` 0 in the next cycle, and a `start` pulse at that edge is ignored.
- R10: A configuration write during a burst leaves the running burst's sequence and length unchanged. The new mode applies from the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the rising edge is the active edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode field from the configuration write |
| ce | input | 1 | Chip enable; low ends any burst |
| start | input | 1 | Address-valid strobe; loads the start address |
| start_addr | input | ADDR_W | Starting word address |
| beat_ready | input | 1 | Consumer accepts the current beat |
| beat_valid | output | 1 | A beat address is present |
| beat_addr | output | ADDR_W | Current word address |

## Verification
The wrap modes are driven from starting words that are unaligned, aligned, and sitting at the top of a 64-word block. These cases separate correct folding inside the window from plain incrementing, and from folding at the wrong window size. Continuous mode is started just below the top of the address space, which shows rollover to zero, and just below a 64-word boundary, which shows that it does not fold. Stalls on `beat_ready`, a drop in `ce`, a `start` while `ce` is low, and a mode write during a burst show that the sequence and its length depend only on accepted beats and on the mode latched at start.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    BM_CONT = 2'b00,
    BM_W8   = 2'b01,
    BM_W16  = 2'b10,
    BM_W32  = 2'b11
  } bmode_e;

  localparam int unsigned LEN_W = 6;

  // number of beats in a wrap burst, 0 means unlimited
  function automatic logic [LEN_W-1:0] burst_len(input bmode_e m);
    case (m)
      BM_W8:   burst_len = 6'd8;
      BM_W16:  burst_len = 6'd16;
      BM_W32:  burst_len = 6'd32;
      default: burst_len = 6'd0;
    endcase
  endfunction

  // low-bit mask of the wrap window
  function automatic logic [4:0] window_mask(input bmode_e m);
    case (m)
      BM_W8:   window_mask = 5'h07;
      BM_W16:  window_mask = 5'h0F;
      BM_W32:  window_mask = 5'h1F;
      default: window_mask = 5'h00;
    endcase
  endfunction

endpackage

// File: rtl/bseq_cfg_reg.sv
module bseq_cfg_reg
  import bseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] mode_in,
  output bmode_e     mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mode_q <= BM_CONT;
    else if (wr) mode_q <= bmode_e'(mode_in);
  end

endmodule

// File: rtl/bseq_addr_step.sv
module bseq_addr_step
  import bseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] cur,
  input  bmode_e            mode,
  output logic [ADDR_W-1:0] nxt
);

  localparam int unsigned HI_W = ADDR_W - 5;

  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] mask_x;

  assign inc    = cur + {{(ADDR_W-1){1'b0}}, 1'b1};
  assign mask_x = {{HI_W{1'b0}}, window_mask(mode)};

  always_comb begin
    if (mode == BM_CONT) nxt = inc;
    else                 nxt = (cur & ~mask_x) | (inc & mask_x);
  end

endmodule

// File: rtl/bseq_beat_ctrl.sv
module bseq_beat_ctrl
  import bseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  bmode_e            cfg_mode,
  input  logic              ready,
  input  logic [ADDR_W-1:0] nxt_addr,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output bmode_e            burst_mode
);

  logic [LEN_W-1:0] beat_cnt;
  logic [LEN_W-1:0] lim;
  logic             last_beat;

  assign lim       = burst_len(burst_mode);
  assign last_beat = (lim != '0) && (beat_cnt == lim - 6'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid      <= 1'b0;
      addr       <= '0;
      beat_cnt   <= '0;
      burst_mode <= BM_CONT;
    end else if (!ce) begin
      valid <= 1'b0;
    end else if (start) begin
      valid      <= 1'b1;
      addr       <= start_addr;
      beat_cnt   <= '0;
      burst_mode <= cfg_mode;
    end else if (valid && ready) begin
      beat_cnt <= beat_cnt + 6'd1;
      if (last_beat) valid <= 1'b0;
      else           addr  <= nxt_addr;
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_mode,
  input  logic              ce,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              beat_ready,
  output logic              beat_valid,
  output logic [ADDR_W-1:0] beat_addr
);

  bmode_e            cfg_q;
  bmode_e            run_mode;
  logic [ADDR_W-1:0] nxt_addr;

  bseq_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cfg_wr),
    .mode_in (cfg_mode),
    .mode_q  (cfg_q)
  );

  bseq_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .cur  (beat_addr),
    .mode (run_mode),
    .nxt  (nxt_addr)
  );

  bseq_beat_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce         (ce),
    .start      (start),
    .start_addr (start_addr),
    .cfg_mode   (cfg_q),
    .ready      (beat_ready),
    .nxt_addr   (nxt_addr),
    .valid      (beat_valid),
    .addr       (beat_addr),
    .burst_mode (run_mode)
  );

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce,
  input logic              start,
  input logic [ADDR_W-1:0] start_addr,
  input logic              beat_ready,
  input logic              beat_valid,
  input logic [ADDR_W-1:0] beat_addr,
  input logic [1:0]        run_mode
);

  logic adv;
  assign adv = ce && !start && beat_valid && beat_ready;

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && start) |=> (beat_valid && beat_addr == $past(start_addr))); // R3

  AST_CE_END: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> !beat_valid); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !start && beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr))); // R8

  AST_CONT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && run_mode == 2'b00) |=> (beat_valid && beat_addr == $past(beat_addr) + 1'b1)); // R4

  AST_WRAP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && run_mode != 2'b00) |=> (!beat_valid || beat_addr[ADDR_W-1:6] == $past(beat_addr[ADDR_W-1:6]))); // R6

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce         (ce),
  .start      (start),
  .start_addr (start_addr),
  .beat_ready (beat_ready),
  .beat_valid (beat_valid),
  .beat_addr  (beat_addr),
  .run_mode   (run_mode)
);

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;

  localparam int unsigned AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_mode = 2'b00;
  logic          ce = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          beat_ready = 1'b0;
  logic          beat_valid;
  logic [AW-1:0] beat_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .ce(ce),
    .start(start), .start_addr(start_addr), .beat_ready(beat_ready),
    .beat_valid(beat_valid), .beat_addr(beat_addr)
  );

  task automatic check(input bit ok, input string req, input logic [AW:0] act, input logic [AW:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] model(input logic [AW-1:0] s, input logic [1:0] m, input int i);
    logic [AW-1:0] msk;
    msk = (m == 2'b01) ? AW'(7) : (m == 2'b10) ? AW'(15) : AW'(31);
    if (m == 2'b00) return s + AW'(i);
    return (s & ~msk) | ((s + AW'(i)) & msk);
  endfunction

  task automatic write_cfg(input logic [1:0] m);
    @(negedge clk); cfg_wr = 1'b1; cfg_mode = m;
    @(negedge clk); cfg_wr = 1'b0; cfg_mode = 2'b00;
  endtask

  task automatic kick(input logic [AW-1:0] a);
    @(negedge clk); start = 1'b1; start_addr = a;
    @(negedge clk); start = 1'b0;
  endtask

  // full burst with ready held high, checking every beat and the end
  task automatic run_burst(input logic [1:0] m, input logic [AW-1:0] a, input int n, input string req);
    bit ok = 1'b1;
    beat_ready = 1'b1;
    kick(a);
    for (int i = 0; i < n; i++) begin
      check(beat_valid && beat_addr == model(a, m, i), req, {beat_valid, beat_addr}, {1'b1, model(a, m, i)});
      if (m != 2'b00 && beat_addr[AW-1:6] != a[AW-1:6]) ok = 1'b0;
      @(negedge clk);
    end
    if (m != 2'b00) begin
      check(!beat_valid, {req, " end"}, {AW'(0), beat_valid}, '0);
      check(ok, "R6 64-word block", {1'b0, beat_addr}, {1'b0, a});
    end
    beat_ready = 1'b0;
  endtask

  task automatic t_reset;
    check(!beat_valid, "R1 reset valid", {AW'(0), beat_valid}, '0);
    run_burst(2'b00, AW'('h3E), 40, "R1 default continuous");
  endtask

  task automatic t_cont_rollover;
    run_burst(2'b00, AW'('hFFFFE), 5, "R4 rollover");
  endtask

  task automatic t_wraps;
    write_cfg(2'b01); run_burst(2'b01, AW'('h3D), 8, "R5 wrap8 R2");
    write_cfg(2'b10); run_burst(2'b10, AW'('h123), 16, "R5 wrap16 R2");
    write_cfg(2'b11); run_burst(2'b11, AW'('h3E), 32, "R5 wrap32 R6 R2");
    write_cfg(2'b01); run_burst(2'b01, AW'('h48), 8, "R7 aligned wrap8");
    write_cfg(2'b11); run_burst(2'b11, AW'('hA0), 32, "R7 aligned wrap32");
  endtask

  task automatic t_stall;
    write_cfg(2'b01);
    beat_ready = 1'b1;
    kick(AW'('h15));
    beat_ready = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(beat_valid && beat_addr == AW'('h15), "R8 stall hold", {beat_valid, beat_addr}, {1'b1, AW'('h15)});
    end
    beat_ready = 1'b1;
    @(negedge clk);
    check(beat_addr == AW'('h16), "R8 resume", {1'b0, beat_addr}, {1'b0, AW'('h16)});
    kick(AW'('h10));
    check(beat_valid && beat_addr == AW'('h10), "R3 restart", {beat_valid, beat_addr}, {1'b1, AW'('h10)});
    beat_ready = 1'b0;
  endtask

  task automatic t_ce;
    write_cfg(2'b00);
    beat_ready = 1'b1;
    kick(AW'('h200));
    @(negedge clk);
    ce = 1'b0;
    @(negedge clk);
    check(!beat_valid, "R9 ce ends", {AW'(0), beat_valid}, '0);
    start = 1'b1; start_addr = AW'('h300);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(!beat_valid, "R9 start ignored", {AW'(0), beat_valid}, '0);
    ce = 1'b1;
    @(negedge clk);
    check(!beat_valid, "R9 stays idle", {AW'(0), beat_valid}, '0);
    beat_ready = 1'b0;
  endtask

  task automatic t_cfg_mid;
    write_cfg(2'b10);
    beat_ready = 1'b1;
    kick(AW'('h7C));
    for (int i = 0; i < 16; i++) begin
      if (i == 3) begin cfg_wr = 1'b1; cfg_mode = 2'b01; end
      if (i == 4) begin cfg_wr = 1'b0; cfg_mode = 2'b00; end
      check(beat_valid && beat_addr == model(AW'('h7C), 2'b10, i), "R10 mid write",
            {beat_valid, beat_addr}, {1'b1, model(AW'('h7C), 2'b10, i)});
      @(negedge clk);
    end
    check(!beat_valid, "R10 length kept", {AW'(0), beat_valid}, '0);
    beat_ready = 1'b0;
    run_burst(2'b01, AW'('h7C), 8, "R10 new mode R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cont_rollover();
    t_wraps();
    t_stall();
    t_ce();
    t_cfg_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(8 * 20000);
        if (!done) begin
          n_chk++; n_fail++;
          $display("FAIL watchdog: actual hung expected done");
        end
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule